// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a bus master that works through a circular list of transmit descriptors in shared memory. Software fills a descriptor, then sets its ownership bit to hand it to the engine. When the engine meets an entry it owns, it fetches the buffer named by that entry and streams the bytes to a MAC. It then takes the MAC's per-frame outcome and writes status into the entry. Writing the status also returns the entry to the host. The engine then pulses a completion interrupt and moves on to the next entry. It stops at the first entry that the host still holds.

A scan starts in three ways: a demand strobe from the host, a built-in poll timer that expires after `POLL_CYCLES` idle cycles, or a restart after a halt. Memory is 16 bits wide and byte addressed. A descriptor is four words at byte offsets 0, 2, 4 and 6 from `cfg_ring_base + 8*index`:
- offset 0: the low 16 address bits of the buffer.
- offset 2: the flag byte in bits 15:8 and the high 8 address bits in bits 7:0.
- offset 4: the buffer length as a negative two's-complement count.
- offset 6: the miscellaneous status word.

Both the memory request and the byte stream are valid/ready. A request or a byte stays unchanged while its valid is high and its ready is low. Read data comes back on `mem_rsp_valid` one or more cycles after the request handshake. Only one read is outstanding at a time. Writes complete at the handshake. The stream has no ready on the response side; the engine always accepts read data.

Top module: `txr_engine`

## Requirements
- R1: The engine reads the flag word (offset 2) first. If bit 15 of that word (ownership, flag value 0x80) is clear, it stops scanning, sends no bytes and writes nothing.
- R2: For an owned entry, the byte count is the negation of the length word. The buffer starts at byte address {high byte, low word}. A byte at an even address is taken from bits 15:8 of its memory word, and a byte at an odd address from bits 7:0. `tx_last` is high on the final byte only.
- R3: A memory request stays valid with unchanged address, write flag and data until it is accepted. A stream byte stays valid with unchanged data and last flag until it is accepted. The two are never valid in the same cycle.
- R4: Completion is one write to offset 2 with bit 15 clear. This write keeps the high address byte. It keeps STP (0x02) and ENP (0x01) as found. It sets DEF (0x04) on deferral, ONE (0x08) on exactly one retry and MORE (0x10) on two or more retries. The ring base must be 8-byte aligned.
- R5: A MAC error sets ERR (0x40) in the flag byte. The status word at offset 6 is then written before the flag word, with retry exhaustion 0x0400, carrier loss 0x0800, late collision 0x1000, underflow 0x4000 and the 10-bit time-domain count in bits 9:0. A frame without error leaves offset 6 untouched.
- R6: An entry that does not have both STP and ENP set, or whose count is zero, sends no bytes. It gets status word 0x8000 and a flag byte of ERR plus its STP/ENP bits, with ownership cleared.
- R7: `tx_done` is a one-cycle pulse in the cycle after the flag write is accepted, once per finished entry.
- R8: The entry index advances modulo 2^`cfg_ring_log2` (this 3-bit field sits in bits 7:5 of the host's ring length byte). The next entry is examined at once.
- R9: While idle and not halted, `poll_demand` puts the first flag read on the memory port in the next cycle.
- R10: With no demand, an idle engine starts a scan after `POLL_CYCLES` cycles.
- R11: After a frame that reports underflow, the engine halts. It ignores demand and the poll timer until `restart`, which starts a scan at once.
- R12: During and after reset, no request, no byte and no done pulse is presented, and the index is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | ADDR_W | Byte address of entry 0, 8-byte aligned |
| cfg_ring_log2 | input | 3 | log2 of the number of entries |
| poll_demand | input | 1 | Start a scan now |
| restart | input | 1 | Leave the halted state and scan |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Byte address (even) |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | MAC accepts the byte |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of the frame |
| res_valid | input | 1 | MAC frame outcome valid (one cycle) |
| res_defer | input | 1 | Frame was deferred |
| res_coll | input | 2 | Retry count: 0, 1, 2 or more |
| res_retry_fail | input | 1 | Retries exhausted |
| res_no_carrier | input | 1 | Carrier lost |
| res_late_coll | input | 1 | Late collision |
| res_underrun | input | 1 | Data underflow |
| res_tdr | input | 10 | Time-domain count |
| tx_done | output | 1 | Completion interrupt pulse |

## Verification
On every cycle, the assertions check that requests and stream bytes hold steady while stalled, and that memory and stream are never valid together. They also check that every flag write clears ownership, and that each done pulse lasts one cycle and follows an accepted flag write. They check too that demand starts a read at once when idle, and that a halted engine stays off the bus. Only the bench's scenarios can show the end results in memory: the negated count and byte ordering for odd and even buffers, the exact status bytes and words, and the misc-before-flag order. The same goes for ring wrap, poll-timer start, the rejected entries, and the restart after underflow.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RFLAG, ST_RLO, ST_RLEN, ST_RBUF,
    ST_SEND, ST_WRES, ST_WMISC, ST_WFLAG
  } txr_state_e;

  localparam logic [7:0] FL_ERR  = 8'h40;
  localparam logic [7:0] FL_MORE = 8'h10;
  localparam logic [7:0] FL_ONE  = 8'h08;
  localparam logic [7:0] FL_DEF  = 8'h04;

  localparam logic [15:0] MS_BUFF = 16'h8000;
  localparam logic [15:0] MS_UFLO = 16'h4000;
  localparam logic [15:0] MS_LCOL = 16'h1000;
  localparam logic [15:0] MS_LCAR = 16'h0800;
  localparam logic [15:0] MS_RTRY = 16'h0400;

  localparam int OFS_ADDR = 0;
  localparam int OFS_FLAG = 2;
  localparam int OFS_LEN  = 4;
  localparam int OFS_MISC = 6;

  typedef struct packed {
    logic       defer;
    logic [1:0] coll;
    logic       underrun;
    logic       late_coll;
    logic       no_carrier;
    logic       retry_fail;
    logic [9:0] tdr;
  } txr_result_t;
endpackage

// File: rtl/txr_poll_timer.sv
module txr_poll_timer #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || expired)   cnt <= '0;
    else                        cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/txr_ring_index.sv
module txr_ring_index #(
  parameter int ADDR_W = 24,
  parameter int LOG2_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [LOG2_W-1:0] ring_log2,
  input  logic [ADDR_W-1:0] ring_base,
  output logic [ADDR_W-1:0] desc_addr
);
  localparam int IW = (1 << LOG2_W) - 1;
  logic [IW-1:0] idx, mask;

  assign mask      = ~({IW{1'b1}} << ring_log2);
  assign desc_addr = ring_base + ADDR_W'({idx, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx <= '0;
    else if (advance) idx <= (idx + IW'(1)) & mask;
  end
endmodule

// File: rtl/txr_status_fmt.sv
module txr_status_fmt
  import txr_pkg::*;
(
  input  logic [1:0]  frame_bits,
  input  logic        bad,
  input  txr_result_t res,
  output logic [7:0]  flag_out,
  output logic [15:0] misc_out,
  output logic        has_err
);
  logic any_err;
  assign any_err = res.underrun | res.late_coll | res.no_carrier | res.retry_fail;

  always_comb begin
    flag_out = {6'b0, frame_bits};
    misc_out = '0;
    has_err  = 1'b1;
    if (bad) begin
      flag_out = flag_out | FL_ERR;
      misc_out = MS_BUFF;
    end else begin
      has_err = any_err;
      if (res.defer)       flag_out = flag_out | FL_DEF;
      if (res.coll == 2'd1) flag_out = flag_out | FL_ONE;
      if (res.coll[1])     flag_out = flag_out | FL_MORE;
      if (any_err)         flag_out = flag_out | FL_ERR;
      misc_out = {6'b0, res.tdr};
      if (res.retry_fail)  misc_out = misc_out | MS_RTRY;
      if (res.no_carrier)  misc_out = misc_out | MS_LCAR;
      if (res.late_coll)   misc_out = misc_out | MS_LCOL;
      if (res.underrun)    misc_out = misc_out | MS_UFLO;
    end
  end
endmodule

// File: rtl/txr_engine.sv
module txr_engine
  import txr_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int POLL_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_ring_base,
  input  logic [2:0]        cfg_ring_log2,
  input  logic              poll_demand,
  input  logic              restart,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [15:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [15:0]       mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  input  logic              res_valid,
  input  logic              res_defer,
  input  logic [1:0]        res_coll,
  input  logic              res_retry_fail,
  input  logic              res_no_carrier,
  input  logic              res_late_coll,
  input  logic              res_underrun,
  input  logic [9:0]        res_tdr,
  output logic              tx_done
);
  txr_state_e        state;
  logic              wait_rsp, halted, done_q, uflo_q, spare_v;
  logic [1:0]        frame_q;
  logic [7:0]        hi_q, byte_q, spare_q, flag_wb_q;
  logic [15:0]       lo_q, cnt_q, misc_wb_q, neg_len;
  logic [ADDR_W-1:0] cur_q, desc_addr;
  logic              is_read, rd_fire, wr_fire, expired, advance, bad_desc;
  logic [7:0]        fmt_flag;
  logic [15:0]       fmt_misc;
  logic              fmt_err;
  txr_result_t       res_in;

  assign res_in = '{defer: res_defer, coll: res_coll, underrun: res_underrun,
                    late_coll: res_late_coll, no_carrier: res_no_carrier,
                    retry_fail: res_retry_fail, tdr: res_tdr};

  txr_poll_timer #(.CYCLES(POLL_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(state == ST_IDLE && !halted), .expired(expired));

  txr_ring_index #(.ADDR_W(ADDR_W), .LOG2_W(3)) index_i (
    .clk(clk), .rst_n(rst_n), .advance(advance), .ring_log2(cfg_ring_log2),
    .ring_base(cfg_ring_base), .desc_addr(desc_addr));

  txr_status_fmt fmt_i (
    .frame_bits(frame_q), .bad(state == ST_RLEN), .res(res_in),
    .flag_out(fmt_flag), .misc_out(fmt_misc), .has_err(fmt_err));

  assign is_read  = (state == ST_RFLAG) || (state == ST_RLO) ||
                    (state == ST_RLEN)  || (state == ST_RBUF);
  assign mem_req_valid = (is_read && !wait_rsp) || (state == ST_WMISC) || (state == ST_WFLAG);
  assign mem_req_write = (state == ST_WMISC) || (state == ST_WFLAG);
  assign mem_req_wdata = (state == ST_WMISC) ? misc_wb_q : {flag_wb_q, hi_q};
  assign rd_fire  = wait_rsp && mem_rsp_valid;
  assign wr_fire  = mem_req_valid && mem_req_ready && mem_req_write;
  assign advance  = (state == ST_WFLAG) && wr_fire;
  assign neg_len  = ~mem_rsp_data + 16'd1;
  assign bad_desc = (frame_q != 2'b11) || (neg_len == 16'd0);

  always_comb begin
    case (state)
      ST_RLO:   mem_req_addr = desc_addr + ADDR_W'(OFS_ADDR);
      ST_RLEN:  mem_req_addr = desc_addr + ADDR_W'(OFS_LEN);
      ST_RBUF:  mem_req_addr = {cur_q[ADDR_W-1:1], 1'b0};
      ST_WMISC: mem_req_addr = desc_addr + ADDR_W'(OFS_MISC);
      default:  mem_req_addr = desc_addr + ADDR_W'(OFS_FLAG);
    endcase
  end

  assign tx_valid = (state == ST_SEND);
  assign tx_data  = byte_q;
  assign tx_last  = (cnt_q == 16'd1);
  assign tx_done  = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  wait_rsp <= 1'b0; halted <= 1'b0; done_q <= 1'b0;
      uflo_q <= 1'b0;    spare_v <= 1'b0;  frame_q <= '0;   hi_q <= '0;
      byte_q <= '0;      spare_q <= '0;    flag_wb_q <= '0; lo_q <= '0;
      cnt_q <= '0;       misc_wb_q <= '0;  cur_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (is_read && mem_req_valid && mem_req_ready) wait_rsp <= 1'b1;
      if (rd_fire) wait_rsp <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (restart) begin
            halted <= 1'b0;
            state  <= ST_RFLAG;
          end else if (!halted && (poll_demand || expired)) begin
            state <= ST_RFLAG;
          end
        end
        ST_RFLAG: if (rd_fire) begin
          frame_q <= mem_rsp_data[9:8];
          hi_q    <= mem_rsp_data[7:0];
          state   <= mem_rsp_data[15] ? ST_RLO : ST_IDLE;
        end
        ST_RLO: if (rd_fire) begin
          lo_q  <= mem_rsp_data;
          state <= ST_RLEN;
        end
        ST_RLEN: if (rd_fire) begin
          cnt_q   <= neg_len;
          cur_q   <= ADDR_W'({hi_q, lo_q});
          spare_v <= 1'b0;
          uflo_q  <= 1'b0;
          if (bad_desc) begin
            flag_wb_q <= fmt_flag;
            misc_wb_q <= fmt_misc;
            state     <= ST_WMISC;
          end else begin
            state <= ST_RBUF;
          end
        end
        ST_RBUF: if (rd_fire) begin
          if (cur_q[0]) begin
            byte_q  <= mem_rsp_data[7:0];
            spare_v <= 1'b0;
          end else begin
            byte_q  <= mem_rsp_data[15:8];
            spare_q <= mem_rsp_data[7:0];
            spare_v <= (cnt_q > 16'd1);
          end
          state <= ST_SEND;
        end
        ST_SEND: if (tx_ready) begin
          cnt_q <= cnt_q - 16'd1;
          cur_q <= cur_q + ADDR_W'(1);
          if (cnt_q == 16'd1) begin
            state <= ST_WRES;
          end else if (spare_v) begin
            byte_q  <= spare_q;
            spare_v <= 1'b0;
          end else begin
            state <= ST_RBUF;
          end
        end
        ST_WRES: if (res_valid) begin
          flag_wb_q <= fmt_flag;
          misc_wb_q <= fmt_misc;
          uflo_q    <= res_underrun;
          state     <= fmt_err ? ST_WMISC : ST_WFLAG;
        end
        ST_WMISC: if (wr_fire) state <= ST_WFLAG;
        ST_WFLAG: if (wr_fire) begin
          done_q <= 1'b1;
          if (uflo_q) begin
            halted <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            state <= ST_RFLAG;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txr_engine_chk.sv
module txr_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_demand,
  input logic              restart,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [15:0]       mem_req_wdata,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [7:0]        tx_data,
  input logic              tx_last,
  input logic              tx_done,
  input logic              halted,
  input logic              in_idle
);
  // R3
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));
  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && mem_req_valid));
  // R4
  own_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_write && mem_req_addr[2:0] == 3'd2 |-> !mem_req_wdata[15]);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);
  // R7
  done_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(mem_req_valid && mem_req_ready && mem_req_write
                      && mem_req_addr[2:0] == 3'd2));
  // R9
  demand_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && !halted && poll_demand |=> mem_req_valid && !mem_req_write);
  // R11
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle && halted && !restart |=> !mem_req_valid);
endmodule

bind txr_engine txr_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .poll_demand(poll_demand), .restart(restart),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .tx_last(tx_last), .tx_done(tx_done), .halted(halted),
  .in_idle(state == txr_pkg::ST_IDLE));

// File: tb/txr_engine_tb_top.sv
`timescale 1ns/1ps
module txr_engine_tb_top;
  localparam int AW = 24;
  localparam int POLL = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, poll_demand, restart;
  logic [AW-1:0] cfg_ring_base;
  logic [2:0] cfg_ring_log2;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [AW-1:0] mem_req_addr;
  logic [15:0] mem_req_wdata, mem_rsp_data;
  logic tx_valid, tx_ready, tx_last, tx_done, res_valid;
  logic [7:0] tx_data;
  logic res_defer, res_retry_fail, res_no_carrier, res_late_coll, res_underrun;
  logic [1:0] res_coll;
  logic [9:0] res_tdr;

  txr_engine #(.ADDR_W(AW), .POLL_CYCLES(POLL)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ring_base(cfg_ring_base), .cfg_ring_log2(cfg_ring_log2),
    .poll_demand(poll_demand), .restart(restart),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .res_valid(res_valid),
    .res_defer(res_defer), .res_coll(res_coll), .res_retry_fail(res_retry_fail),
    .res_no_carrier(res_no_carrier), .res_late_coll(res_late_coll),
    .res_underrun(res_underrun), .res_tdr(res_tdr), .tx_done(tx_done));

  int n_chk = 0, n_bad = 0, cyc = 0, done_cnt = 0, req_cnt = 0, wseq = 0, res_dly = 0;
  logic [15:0] mem [0:1023];
  logic hw_en = 1'b0;
  logic [10:0] hw_addr = '0;
  logic [15:0] hw_data = '0;
  int misc_at [4];
  int flag_at [4];
  logic [16:0] res_q [$];
  logic [8:0]  exp_q [$];
  logic [16:0] res_hold;
  logic res_pend;
  logic stall_seen = 1'b0;
  logic [8:0] stall_val;

  function automatic logic [15:0] pat(input int w);
    return {8'(w) ^ 8'hA5, 8'(w) + 8'h3C};
  endfunction

  function automatic logic [7:0] ebyte(input logic [15:0] a);
    logic [15:0] w;
    w = pat(int'(a[10:1]));
    return a[0] ? w[7:0] : w[15:8];
  endfunction

  function automatic logic [16:0] mkres(input logic d, input logic [1:0] c, input logic uf,
                                        input logic lc, input logic nc, input logic rf,
                                        input logic [9:0] tdr);
    return {d, c, uf, lc, nc, rf, tdr};
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory, ready patterns and MAC outcome model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    tx_ready <= (cyc % 5) != 2;
    mem_rsp_valid <= 1'b0;
    res_valid <= 1'b0;
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= (i < 256) ? 16'h0 : pat(i);
      res_pend <= 1'b0;
      mem_rsp_data <= '0;
      {res_defer, res_coll, res_underrun, res_late_coll, res_no_carrier,
       res_retry_fail, res_tdr} <= '0;
    end else begin
      if (hw_en) mem[hw_addr[10:1]] <= hw_data;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr[10:1]] <= mem_req_wdata;
          wseq <= wseq + 1;
          if (mem_req_addr[2:0] == 3'd6) misc_at[mem_req_addr[4:3]] <= wseq;
          if (mem_req_addr[2:0] == 3'd2) flag_at[mem_req_addr[4:3]] <= wseq;
        end else begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data <= mem[mem_req_addr[10:1]];
        end
      end
      if (tx_valid && tx_ready && tx_last) begin
        res_hold <= res_q.pop_front();
        res_dly <= 2;
        res_pend <= 1'b1;
      end else if (res_pend) begin
        if (res_dly == 0) begin
          res_valid <= 1'b1;
          {res_defer, res_coll, res_underrun, res_late_coll, res_no_carrier,
           res_retry_fail, res_tdr} <= res_hold;
          res_pend <= 1'b0;
        end else begin
          res_dly <= res_dly - 1;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_done) done_cnt++;
      if (mem_req_valid) req_cnt++;
      if (stall_seen) begin
        check("R3 stalled byte held", {tx_valid, tx_last, tx_data}, {1'b1, stall_val});
      end
      stall_seen = tx_valid && !tx_ready;
      stall_val = {tx_last, tx_data};
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) check("R2 unexpected byte", {tx_last, tx_data}, 9'h1FF);
        else check("R2 byte/last", {tx_last, tx_data}, exp_q.pop_front());
      end
    end
  end

  task automatic host_wr(input logic [15:0] a, input logic [15:0] v);
    @(negedge clk);
    hw_en = 1'b1; hw_addr = a[10:0]; hw_data = v;
    @(negedge clk);
    hw_en = 1'b0;
  endtask

  function automatic logic [15:0] rdw(input logic [15:0] a);
    return mem[a[10:1]];
  endfunction

  // driver: fills a descriptor and pushes the expected bytes and outcome
  task automatic post(input int idx, input logic [7:0] hi, input logic [15:0] lo,
                      input int count, input logic [7:0] flg, input logic [16:0] res,
                      input bit sends);
    logic [15:0] d;
    d = 16'h100 + 16'(idx * 8);
    host_wr(d + 16'd6, 16'h1234);
    host_wr(d, lo);
    host_wr(d + 16'd4, 16'(-count));
    if (sends) begin
      for (int k = 0; k < count; k++)
        exp_q.push_back({(k == count - 1), ebyte(lo + 16'(k))});
      res_q.push_back(res);
    end
    host_wr(d + 16'd2, {flg, hi});
  endtask

  task automatic pulse(input bit which);
    @(negedge clk);
    if (which) restart = 1'b1; else poll_demand = 1'b1;
    @(negedge clk);
    restart = 1'b0; poll_demand = 1'b0;
  endtask

  task automatic wait_done(input int n, input int limit, input string tag);
    int t;
    t = 0;
    while (done_cnt < n && t < limit) begin
      @(negedge clk);
      t++;
    end
    check(tag, done_cnt, n);
    repeat (20) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rc;
    rst_n = 1'b0; poll_demand = 1'b0; restart = 1'b0;
    cfg_ring_base = 24'h000100; cfg_ring_log2 = 3'd2;
    repeat (4) @(negedge clk);
    // R12 reset state
    check("R12 reset outputs", {mem_req_valid, tx_valid, tx_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset", {mem_req_valid, tx_valid, tx_done}, 0);
    @(negedge clk);
    // R9 demand starts a read in the next cycle
    poll_demand = 1'b1;
    @(negedge clk);
    poll_demand = 1'b0;
    check("R9 demand read", {mem_req_valid, mem_req_write}, 2'b10);
    check("R9 first read is entry 0 flag", int'(mem_req_addr), 24'h000102);
    repeat (10) @(negedge clk);

    // even buffer with odd count, then odd buffer with high address byte
    post(0, 8'h00, 16'h0200, 5, 8'h83, mkres(0, 0, 0, 0, 0, 0, 0), 1);
    post(1, 8'h12, 16'h0241, 4, 8'h83, mkres(1, 2'd1, 0, 0, 0, 0, 0), 1);
    pulse(0);
    wait_done(2, 3000, "R7 two completions");
    check("R4 flag0 writeback", rdw(16'h102), 16'h0300);
    check("R5 misc0 untouched on success", rdw(16'h106), 16'h1234);
    check("R4 flag1 DEF ONE kept hi", rdw(16'h10A), 16'h0F12);
    check("R1 unowned entry 2 untouched", rdw(16'h112), 16'h0000);
    check("R2 all bytes sent", exp_q.size(), 0);

    // error outcome and unsupported frame bits
    post(3, 8'h00, 16'h0400, 2, 8'h82, '0, 0);
    post(2, 8'h00, 16'h0300, 3, 8'h83, mkres(0, 2'd2, 0, 1, 0, 0, 10'd5), 1);
    pulse(0);
    wait_done(4, 3000, "R7 four completions");
    check("R5 flag2 ERR MORE", rdw(16'h112), 16'h5300);
    check("R5 misc2 late coll tdr", rdw(16'h116), 16'h1005);
    check("R5 misc before flag", int'(misc_at[2] < flag_at[2]), 1);
    check("R6 flag3 rejected", rdw(16'h11A), 16'h4200);
    check("R6 misc3 buffer error", rdw(16'h11E), 16'h8000);

    // R8 wrap to entry 0, single-byte frame, three retries
    post(0, 8'h00, 16'h0500, 1, 8'h83, mkres(0, 2'd3, 0, 0, 0, 0, 0), 1);
    pulse(0);
    wait_done(5, 3000, "R8 wrapped completion");
    check("R8 flag0 MORE after wrap", rdw(16'h102), 16'h1300);

    // R11 underflow halts until restart
    post(1, 8'h00, 16'h0600, 6, 8'h83, mkres(0, 0, 1, 0, 0, 0, 0), 1);
    pulse(0);
    wait_done(6, 3000, "R11 underflow completion");
    check("R11 flag1 ERR", rdw(16'h10A), 16'h4300);
    check("R11 misc1 underflow", rdw(16'h10E), 16'h4000);
    post(2, 8'h00, 16'h0700, 2, 8'h83, mkres(0, 0, 0, 0, 0, 0, 0), 1);
    rc = req_cnt;
    pulse(0);
    repeat (3 * POLL) @(negedge clk);
    check("R11 no requests while halted", req_cnt - rc, 0);
    check("R11 no completion while halted", done_cnt, 6);
    pulse(1);
    wait_done(7, 3000, "R11 restart completion");
    check("R11 flag2 after restart", rdw(16'h112), 16'h0300);

    // R10 poll timer only; zero-length entry is rejected (R6)
    post(3, 8'h00, 16'h0000, 0, 8'h83, '0, 0);
    wait_done(8, 4 * POLL, "R10 poll-started completion");
    check("R6 zero count flag3", rdw(16'h11A), 16'h4300);
    check("R6 zero count misc3", rdw(16'h11E), 16'h8000);
    check("R2 no leftover bytes", exp_q.size(), 0);
    check("R5 outcomes consumed", res_q.size(), 0);
    finish_run();
  end
endmodule